// File: doc/BRIEF.md
# Module Slot Window Decoder with Byte-Lane Order Control

This block sits between a host access path and up to four plug-in module slots. A host request names one of four windows: a small configuration window, a 1 KiB window shared by three small per-slot spaces (identification, interrupt and general I/O), a memory window for 16-bit accesses and a memory window for byte accesses. The block splits the address of each request into a slot number, a sub-space code and an offset, and presents them on a module-side request port in the same cycle.

Three flags, written through the configuration window, put the register window, the shared small-space window and the 16-bit memory window into big-endian mode. In that mode a byte access has address bit 0 inverted before decoding, and a 16-bit access has its two data bytes exchanged, both on write data and on returned read data. Accesses to an empty slot, and accesses wider than the window allows, never reach a module. Reads of such accesses return zero. A read at interrupt-space offset 0 or 2 also raises a one-cycle acknowledge strobe for line 0 or line 1 of that slot.

Every read returns its data exactly one cycle after the request. Module read data arrives one cycle after the module-side request.

Top module: `ipsd_window_decoder`

## Requirements
- R1: A byte read in the configuration window (`host_win`=0) at a 7-bit byte address A returns `A ^ CFG_SEED` (default 0x3C) on `host_rdata[7:0]`, with upper bits zero. At A = 0x2B, 0x2F or 0x33, bit 0 is replaced by the corresponding flag.
- R2: A byte write to configuration byte 0x2B, 0x2F or 0x33 loads bit 0 of the write data into the flag for the register window, the small-space window or the 16-bit memory window, respectively. Writes to any other configuration byte change nothing, and reset clears all three flags.
- R3: In the small-space window (`host_win`=1), the slot is address bits 9:8. Field 7:6 equal to 2 gives identification space (`mod_space`=1) and equal to 3 gives interrupt space (`mod_space`=2), each with offset bits 5:0. Any other value gives I/O space (`mod_space`=0) with offset bits 6:0.
- R4: In the 16-bit memory window (`host_win`=2), the slot is address bits 24:23, the offset is bits 22:0 and `mod_space`=3.
- R5: In the byte memory window (`host_win`=3), the slot is address bits 23:22, the offset is bits 21:0 and `mod_space`=4. No endian adjustment is ever applied in this window.
- R6: With the window's flag set, a byte access (`host_size`=0) in the small-space or 16-bit memory window inverts address bit 0 before decoding.
- R7: With the window's flag set, a 16-bit access (`host_size`=1) in those windows exchanges the two bytes of the write data on `mod_wdata` and of the returned read data on `host_rdata`.
- R8: An access whose slot bit in `mod_present` is 0 raises no `mod_req`, and a read of it returns 0.
- R9: A 16-bit access to the configuration window or the byte memory window is dropped. It raises no `mod_req`, changes no flag, and a read of it returns 0.
- R10: A read forwarded to interrupt space at offset 0 or 2 drives `int_ack` bit (slot*2 + offset/2) high in the same cycle as `mod_req`. Writes and other offsets raise no strobe.
- R11: Each read request gives `host_rvalid` exactly one cycle later, carrying the module data (returned one cycle after `mod_req`), the configuration byte, or zero. `host_rdata` is zero whenever `host_rvalid` is low.
- R12: `regwin_be` equals the register-window flag and changes on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, one per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_win | input | 2 | Window: 0 config, 1 small spaces, 2 mem16, 3 mem8 |
| host_size | input | 1 | 0 = byte, 1 = 16-bit |
| host_addr | input | 25 | Byte address within the window |
| host_wdata | input | 16 | Write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| host_rdata | output | 16 | Read data |
| mod_present | input | 4 | One bit per slot, 1 = module fitted |
| mod_req | output | 1 | Module-side request |
| mod_we | output | 1 | Module-side write flag |
| mod_slot | output | 2 | Target slot |
| mod_space | output | 3 | Space code 0 I/O, 1 ID, 2 INT, 3 mem16, 4 mem8 |
| mod_offset | output | 23 | Offset within the space |
| mod_wdata | output | 16 | Write data after lane ordering |
| mod_rdata | input | 16 | Module read data, one cycle after mod_req |
| int_ack | output | 8 | Acknowledge strobes, bit slot*2+line |
| regwin_be | output | 1 | Register-window big-endian flag |

## Verification
The module-side request, its decoded fields, the lane-ordered write data and the acknowledge strobes all depend only on the current inputs and the stored flags. The bench drives each request just after a falling edge and compares these outputs one time unit later, within the same cycle. Read results are due one clock after the request, so the reference model keeps the expected value of the previous read and compares `host_rvalid` and `host_rdata` at the next falling edge, before it drives the next request. A flag written in one cycle takes effect from the next request onward, and the model updates its copy of the flags only after it has scored the writing cycle.

// File: rtl/ipsd_pkg.sv
package ipsd_pkg;

    localparam int SLOT_W    = 2;
    localparam int N_SLOTS   = 1 << SLOT_W;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 25;
    localparam int OFS_W     = ADDR_W - SLOT_W;
    localparam int M8_AW     = ADDR_W - 1;
    localparam int IO_AW     = 10;
    localparam int SUB_LSB   = IO_AW - SLOT_W - 2;
    localparam int SMALL_OFS = 6;
    localparam int IO_OFS    = 7;
    localparam int CFG_AW    = 7;
    localparam int N_FLAGS   = 3;
    localparam int ACK_W     = 2 * N_SLOTS;

    localparam int FL_REG = 0;
    localparam int FL_IO  = 1;
    localparam int FL_M16 = 2;

    typedef enum logic [1:0] {
        WIN_CFG = 2'd0,
        WIN_IO  = 2'd1,
        WIN_M16 = 2'd2,
        WIN_M8  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO  = 3'd0,
        SP_ID  = 3'd1,
        SP_INT = 3'd2,
        SP_M16 = 3'd3,
        SP_M8  = 3'd4
    } space_e;

    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_CFG  = 2'd1,
        RK_MOD  = 2'd2
    } rkind_e;

    typedef struct packed {
        logic              ok;
        logic              swap;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFS_W-1:0]  offset;
    } decode_t;

    // Configuration byte holding the flag of window index idx
    function automatic logic [CFG_AW-1:0] flag_addr(input int idx);
        return CFG_AW'(8'h2B + 4 * idx);
    endfunction

endpackage

// File: rtl/ipsd_lane_swap.sv
module ipsd_lane_swap #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign dout[g*8 +: 8] = en ? din[(NB-1-g)*8 +: 8] : din[g*8 +: 8];
    end
endmodule

// File: rtl/ipsd_cfg_flags.sv
module ipsd_cfg_flags
    import ipsd_pkg::*;
#(
    parameter logic [7:0] CFG_SEED = 8'h3C
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CFG_AW-1:0]  addr,
    input  logic               wbit,
    output logic [N_FLAGS-1:0] flags,
    output logic [7:0]         rd_byte
);
    logic [N_FLAGS-1:0] hit;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_hit
        assign hit[g] = (addr == flag_addr(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_FLAGS; i++) begin
                if (hit[i]) flags[i] <= wbit;
            end
        end
    end

    always_comb begin
        rd_byte = {1'b0, addr} ^ CFG_SEED;
        if (|hit) rd_byte[0] = |(hit & flags);
    end
endmodule

// File: rtl/ipsd_addr_split.sv
module ipsd_addr_split
    import ipsd_pkg::*;
(
    input  win_e              win,
    input  logic              half,
    input  logic              be_io,
    input  logic              be_m16,
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        logic [ADDR_W-1:0] a;
        a   = addr;
        dec = '0;
        case (win)
            WIN_IO: begin
                if (be_io && !half) a[0] = ~addr[0];
                dec.ok   = 1'b1;
                dec.swap = be_io && half;
                dec.slot = a[IO_AW-1 -: SLOT_W];
                case (a[SUB_LSB +: 2])
                    2'd2: begin
                        dec.space  = SP_ID;
                        dec.offset = OFS_W'(a[SMALL_OFS-1:0]);
                    end
                    2'd3: begin
                        dec.space  = SP_INT;
                        dec.offset = OFS_W'(a[SMALL_OFS-1:0]);
                    end
                    default: begin
                        dec.space  = SP_IO;
                        dec.offset = OFS_W'(a[IO_OFS-1:0]);
                    end
                endcase
            end
            WIN_M16: begin
                if (be_m16 && !half) a[0] = ~addr[0];
                dec.ok     = 1'b1;
                dec.swap   = be_m16 && half;
                dec.slot   = a[ADDR_W-1 -: SLOT_W];
                dec.space  = SP_M16;
                dec.offset = a[OFS_W-1:0];
            end
            WIN_M8: begin
                dec.ok     = !half;
                dec.slot   = a[M8_AW-1 -: SLOT_W];
                dec.space  = SP_M8;
                dec.offset = OFS_W'(a[M8_AW-SLOT_W-1:0]);
            end
            default: begin
                dec.ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ipsd_window_decoder.sv
module ipsd_window_decoder
    import ipsd_pkg::*;
#(
    parameter logic [7:0] CFG_SEED = 8'h3C
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [1:0]               host_win,
    input  logic                     host_size,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic                     host_rvalid,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic [N_SLOTS-1:0]       mod_present,
    output logic                     mod_req,
    output logic                     mod_we,
    output logic [SLOT_W-1:0]        mod_slot,
    output logic [2:0]               mod_space,
    output logic [OFS_W-1:0]         mod_offset,
    output logic [DATA_W-1:0]        mod_wdata,
    input  logic [DATA_W-1:0]        mod_rdata,
    output logic [ACK_W-1:0]         int_ack,
    output logic                     regwin_be
);
    win_e               win;
    decode_t            dec;
    logic [N_FLAGS-1:0] flags;
    logic [7:0]         cfg_byte;
    logic               fwd;
    logic               rd_req;
    logic               cfg_wr;
    logic               rd_pend;
    rkind_e             rd_kind;
    logic               rd_swap;
    logic [7:0]         cfg_q;
    logic [DATA_W-1:0]  rd_lanes;

    assign win    = win_e'(host_win);
    assign rd_req = host_req && !host_we;
    assign cfg_wr = host_req && host_we && (win == WIN_CFG) && !host_size;

    ipsd_cfg_flags #(.CFG_SEED(CFG_SEED)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .addr    (host_addr[CFG_AW-1:0]),
        .wbit    (host_wdata[0]),
        .flags   (flags),
        .rd_byte (cfg_byte)
    );

    ipsd_addr_split u_split (
        .win    (win),
        .half   (host_size),
        .be_io  (flags[FL_IO]),
        .be_m16 (flags[FL_M16]),
        .addr   (host_addr),
        .dec    (dec)
    );

    assign fwd        = host_req && dec.ok && mod_present[dec.slot];
    assign mod_req    = fwd;
    assign mod_we     = host_we;
    assign mod_slot   = dec.slot;
    assign mod_space  = dec.space;
    assign mod_offset = dec.offset;
    assign regwin_be  = flags[FL_REG];

    ipsd_lane_swap #(.W(DATA_W)) u_wr_lanes (
        .en   (dec.swap),
        .din  (host_wdata),
        .dout (mod_wdata)
    );

    // Acknowledge strobe for interrupt-space reads at offsets 0 and 2
    always_comb begin
        int_ack = '0;
        if (fwd && !host_we && dec.space == SP_INT &&
            dec.offset[SMALL_OFS-1:2] == '0 && !dec.offset[0] &&
            dec.offset[OFS_W-1:SMALL_OFS] == '0) begin
            int_ack[{dec.slot, dec.offset[1]}] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rd_kind <= RK_ZERO;
            rd_swap <= 1'b0;
            cfg_q   <= '0;
        end else begin
            rd_pend <= rd_req;
            if (rd_req) begin
                if (win == WIN_CFG) begin
                    rd_kind <= host_size ? RK_ZERO : RK_CFG;
                end else begin
                    rd_kind <= fwd ? RK_MOD : RK_ZERO;
                end
                rd_swap <= dec.swap;
                cfg_q   <= cfg_byte;
            end
        end
    end

    ipsd_lane_swap #(.W(DATA_W)) u_rd_lanes (
        .en   (rd_swap),
        .din  (mod_rdata),
        .dout (rd_lanes)
    );

    assign host_rvalid = rd_pend;

    always_comb begin
        host_rdata = '0;
        if (rd_pend) begin
            case (rd_kind)
                RK_CFG:  host_rdata = {{(DATA_W-8){1'b0}}, cfg_q};
                RK_MOD:  host_rdata = rd_lanes;
                default: host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ipsd_window_checker.sv
module ipsd_window_checker
    import ipsd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_req,
    input logic               host_we,
    input logic [1:0]         host_win,
    input logic               host_size,
    input logic               host_rvalid,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [N_SLOTS-1:0] mod_present,
    input logic               mod_req,
    input logic               mod_we,
    input logic [SLOT_W-1:0]  mod_slot,
    input logic [2:0]         mod_space,
    input logic [ACK_W-1:0]   int_ack
);
    AST_ACK_NEEDS_INT_READ: assert property (@(posedge clk) disable iff (rst)
        (int_ack != '0) |-> (mod_req && !mod_we && mod_space == 3'd2)); // R10

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_ack)); // R10

    AST_ACK_SLOT_MATCH: assert property (@(posedge clk) disable iff (rst)
        (int_ack != '0) |-> (((int_ack >> {mod_slot, 1'b0}) & 8'h03) != 8'h00)); // R10

    AST_REQ_SLOT_PRESENT: assert property (@(posedge clk) disable iff (rst)
        mod_req |-> mod_present[mod_slot]); // R8

    AST_NO_REQ_FROM_CFG: assert property (@(posedge clk) disable iff (rst)
        mod_req |-> (host_win != 2'd0)); // R9

    AST_M8_BYTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mod_req && mod_space == 3'd4) |-> !host_size); // R9

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_we) |=> host_rvalid); // R11

    AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !(host_req && !host_we) |=> !host_rvalid); // R11

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !host_rvalid |-> (host_rdata == '0)); // R11
endmodule

bind ipsd_window_decoder ipsd_window_checker u_chk (.*);

// File: tb/test_ipsd_window_decoder.sv
module test_ipsd_window_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_win = 2'd0;
    logic        host_size = 1'b0;
    logic [24:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_rvalid;
    logic [15:0] host_rdata;
    logic [3:0]  mod_present = 4'hF;
    logic        mod_req;
    logic        mod_we;
    logic [1:0]  mod_slot;
    logic [2:0]  mod_space;
    logic [22:0] mod_offset;
    logic [15:0] mod_wdata;
    logic [15:0] mod_rdata;
    logic [7:0]  int_ack;
    logic        regwin_be;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [2:0]  be_ref = 3'b000;
    logic        pend_v = 1'b0;
    logic [15:0] pend_d = '0;
    string       pend_tag = "R11";

    always #2 clk = ~clk;

    ipsd_window_decoder i_ipsd_window_decoder (.*);

    // Module side: answers one cycle after each read request
    always @(posedge clk) begin
        if (rst) mod_rdata <= '0;
        else if (mod_req && !mod_we) mod_rdata <= {mod_slot, mod_space, mod_offset[10:0]};
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sw16(input logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    task automatic cyc(input logic req, input logic we, input logic [1:0] win,
                       input logic sz, input logic [24:0] addr, input logic [15:0] wd,
                       input logic [3:0] pres, input string tag);
        logic [24:0] a;
        logic        ok;
        logic        swp;
        logic [1:0]  slot;
        logic [2:0]  sp;
        logic [22:0] ofs;
        logic        ereq;
        logic [7:0]  eack;
        logic [7:0]  cb;
        logic [15:0] rd;
        int          fi;
        // previous read result
        chk(host_rvalid === pend_v, "R11", "rvalid", 32'(host_rvalid), 32'(pend_v));
        chk(host_rdata === pend_d, pend_v ? pend_tag : "R11", "rdata", 32'(host_rdata), 32'(pend_d));
        chk(regwin_be === be_ref[0], "R12", "regwin_be", 32'(regwin_be), 32'(be_ref[0]));
        host_req = req; host_we = we; host_win = win; host_size = sz;
        host_addr = addr; host_wdata = wd; mod_present = pres;
        #1;
        a = addr; ok = 0; swp = 0; slot = 0; sp = 0; ofs = 0; rd = 0; fi = -1;
        case (win)
            2'd1: begin
                if (!sz && be_ref[1]) a[0] = ~a[0];
                ok = 1; swp = be_ref[1] && sz; slot = a[9:8];
                if (a[7:6] == 2'd2)      begin sp = 1; ofs = 23'(a[5:0]); end
                else if (a[7:6] == 2'd3) begin sp = 2; ofs = 23'(a[5:0]); end
                else                     begin sp = 0; ofs = 23'(a[6:0]); end
            end
            2'd2: begin
                if (!sz && be_ref[2]) a[0] = ~a[0];
                ok = 1; swp = be_ref[2] && sz; slot = a[24:23]; sp = 3; ofs = a[22:0];
            end
            2'd3: begin
                ok = !sz; slot = a[23:22]; sp = 4; ofs = 23'(a[21:0]);
            end
            default: ok = 0;
        endcase
        ereq = req && ok && pres[slot];
        eack = 0;
        if (ereq && !we && sp == 2 && (ofs == 0 || ofs == 2)) eack[slot*2 + ofs/2] = 1'b1;
        if (win == 2'd0) begin
            if (a[6:0] == 7'h2B) fi = 0;
            if (a[6:0] == 7'h2F) fi = 1;
            if (a[6:0] == 7'h33) fi = 2;
        end
        chk(mod_req === ereq, tag, "mod_req", 32'(mod_req), 32'(ereq));
        chk(int_ack === eack, tag, "int_ack", 32'(int_ack), 32'(eack));
        if (ereq) begin
            chk(mod_slot === slot, tag, "mod_slot", 32'(mod_slot), 32'(slot));
            chk(mod_space === sp, tag, "mod_space", 32'(mod_space), 32'(sp));
            chk(mod_offset === ofs, tag, "mod_offset", 32'(mod_offset), 32'(ofs));
            chk(mod_we === we, tag, "mod_we", 32'(mod_we), 32'(we));
            if (we) chk(mod_wdata === (swp ? sw16(wd) : wd), tag, "mod_wdata",
                        32'(mod_wdata), 32'(swp ? sw16(wd) : wd));
        end
        if (win == 2'd0 && !sz) begin
            cb = {1'b0, a[6:0]} ^ 8'h3C;
            if (fi >= 0) cb[0] = be_ref[fi];
            rd = {8'h00, cb};
        end else if (ereq) begin
            rd = {slot, sp, ofs[10:0]};
            if (swp) rd = sw16(rd);
        end
        pend_v = req && !we;
        pend_d = pend_v ? rd : 16'h0;
        pend_tag = tag;
        if (req && we && win == 2'd0 && !sz && fi >= 0) be_ref[fi] = wd[0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Reset state
        chk(host_rvalid === 1'b0, "R11", "reset rvalid", 32'(host_rvalid), 0);
        chk(regwin_be === 1'b0, "R2", "reset flag", 32'(regwin_be), 0);
        chk(int_ack === 8'h0, "R10", "reset ack", 32'(int_ack), 0);
        // R1 configuration constants and flag bytes
        cyc(1, 0, 0, 0, 25'h00, 0, 4'hF, "R1");
        cyc(1, 0, 0, 0, 25'h10, 0, 4'hF, "R1");
        cyc(1, 0, 0, 0, 25'h2B, 0, 4'hF, "R1");
        cyc(1, 0, 0, 0, 25'h7F, 0, 4'hF, "R1");
        // R2 ignored write to a plain byte
        cyc(1, 1, 0, 0, 25'h10, 16'hFFFF, 4'hF, "R2");
        cyc(1, 0, 0, 0, 25'h10, 0, 4'hF, "R2");
        // R3 small-space window
        cyc(1, 0, 1, 0, 25'h1C5, 0, 4'hF, "R3");
        cyc(1, 0, 1, 0, 25'h285, 0, 4'hF, "R3");
        cyc(1, 0, 1, 1, 25'h37F, 0, 4'hF, "R3");
        cyc(1, 0, 1, 0, 25'h012, 0, 4'hF, "R3");
        cyc(1, 1, 1, 1, 25'h0AB, 16'h1234, 4'hF, "R3");
        // R4 / R5 memory windows
        cyc(1, 0, 2, 1, 25'h1812345, 0, 4'hF, "R4");
        cyc(1, 1, 2, 1, 25'h0FFFFFF, 16'hBEEF, 4'hF, "R4");
        cyc(1, 0, 3, 0, 25'h182ABCD, 0, 4'hF, "R5");
        cyc(1, 1, 3, 0, 25'h0C00001, 16'h00A5, 4'hF, "R5");
        // R8 empty slots
        cyc(1, 0, 1, 0, 25'h012, 0, 4'b1010, "R8");
        cyc(1, 1, 2, 1, 25'h1000010, 16'h5555, 4'b1010, "R8");
        cyc(1, 0, 1, 0, 25'h112, 0, 4'b1010, "R8");
        // R9 over-wide accesses
        cyc(1, 0, 3, 1, 25'h0000010, 0, 4'hF, "R9");
        cyc(1, 1, 3, 1, 25'h0000010, 16'h7777, 4'hF, "R9");
        cyc(1, 1, 0, 1, 25'h2F, 16'h0001, 4'hF, "R9");
        cyc(1, 0, 0, 0, 25'h2F, 0, 4'hF, "R9");
        cyc(1, 0, 0, 1, 25'h2F, 0, 4'hF, "R9");
        // R10 acknowledge strobes
        cyc(1, 0, 1, 0, 25'h3C0, 0, 4'hF, "R10");
        cyc(1, 0, 1, 0, 25'h0C2, 0, 4'hF, "R10");
        cyc(1, 0, 1, 0, 25'h0C1, 0, 4'hF, "R10");
        cyc(1, 0, 1, 0, 25'h0C4, 0, 4'hF, "R10");
        cyc(1, 1, 1, 0, 25'h3C0, 16'h0000, 4'hF, "R10");
        cyc(1, 0, 1, 0, 25'h3C0, 0, 4'b0111, "R10");
        // R2 / R12 set all flags
        cyc(1, 1, 0, 0, 25'h2B, 16'h0001, 4'hF, "R2");
        cyc(1, 1, 0, 0, 25'h2F, 16'h0001, 4'hF, "R2");
        cyc(1, 1, 0, 0, 25'h33, 16'h0001, 4'hF, "R2");
        cyc(1, 0, 0, 0, 25'h2B, 0, 4'hF, "R12");
        cyc(1, 0, 0, 0, 25'h2F, 0, 4'hF, "R2");
        cyc(1, 0, 0, 0, 25'h33, 0, 4'hF, "R2");
        // R6 byte address flip
        cyc(1, 0, 1, 0, 25'h285, 0, 4'hF, "R6");
        cyc(1, 0, 2, 0, 25'h1812345, 0, 4'hF, "R6");
        cyc(1, 1, 1, 0, 25'h0C1, 16'h00C3, 4'hF, "R6");
        cyc(1, 0, 1, 0, 25'h3C1, 0, 4'hF, "R6");
        // R7 halfword lane swap
        cyc(1, 1, 1, 1, 25'h012, 16'h1234, 4'hF, "R7");
        cyc(1, 0, 1, 1, 25'h013, 0, 4'hF, "R7");
        cyc(1, 0, 2, 1, 25'h0812344, 0, 4'hF, "R7");
        cyc(1, 1, 2, 1, 25'h1000002, 16'hA1B2, 4'hF, "R7");
        // R5 byte memory window never adjusted
        cyc(1, 0, 3, 0, 25'h182ABCD, 0, 4'hF, "R5");
        // R2 clearing a flag
        cyc(1, 1, 0, 0, 25'h2F, 16'h0000, 4'hF, "R2");
        cyc(1, 0, 1, 0, 25'h285, 0, 4'hF, "R2");
        cyc(0, 0, 1, 0, 25'h0, 0, 4'hF, "R11");
        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 2,
                25'($urandom), 16'($urandom), 4'($urandom), "R11");
        end
        cyc(0, 0, 0, 0, 25'h0, 0, 4'hF, "R11");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule